// File: doc/BRIEF.md
# Scaled-Radian Phase Accumulator

This block generates the running phase for a tone generator. A signed step held in a register is added to a running phase each time a downstream rotator takes a phase value. The phase is kept in the scaled-radian range, where the interval -1 to +1 stands for -π to +π. The phase leaves the block on a valid/ready stream. The step size sets how fast the phase turns, and so the tone frequency.

A new step is written through a valid/ready input whose ready is always high. A last flag travels with each step and is repeated on every output beat. Both the phase and the step use a 16-bit signed fixed-point format with 3 integer bits and 13 fractional bits, so 1.0 is 8192. When the phase would leave the range it is folded back by a full turn of 2.0 (16384). It does not rely on binary overflow. A clear input zeroes the phase without touching the stored step. A synchronous reset clears all state.

Top module: `phase_stepper`

## Requirements
- R1: While `rst` is high, the stored step, phase and last flag all return to zero, and `ph_valid` is low. `ph_valid` goes high at the first clock edge after `rst` falls and stays high until the next reset.
- R2: `inc_ready` is always high.
- R3: `inc_data` is a 16-bit two's-complement step in 3.13 format and is stored at every clock edge where `inc_valid` is high. A stored step is first used by the accumulation step that happens after the edge that stored it, so a step loaded in a firing cycle does not affect that cycle's update.
- R4: At a clock edge where `ph_valid` and `ph_ready` are both high and `clr` is low, the phase becomes the wrapped sum of the phase and the stored step.
- R5: At an edge with no accepted beat and no clear, the phase keeps its value.
- R6: A sum of 8192 (+1.0) or more has 16384 subtracted from it. The result is then negative.
- R7: A sum below -8192 (-1.0) has 16384 added to it. The result is then zero or positive.
- R8: `ph_data` always lies in [-8192, 8191]. The sums 8191 and -8192 are kept unchanged.
- R9: At an edge where `clr` is high, the phase becomes 0 whatever `ph_ready` is. The stored step and last flag are kept.
- R10: `ph_last` equals the `inc_last` value stored with the most recently accepted step.
- R11: Steps of magnitude up to and including 8192 wrap correctly with a single correction. For example, from 0 a step of +8192 gives -8192, and from -8192 a step of -8192 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Zeroes the phase, keeps the step |
| inc_valid | input | 1 | Step write strobe |
| inc_data | input | PH_W (16) | Signed step, 3.13 format |
| inc_last | input | 1 | Last flag stored with the step |
| inc_ready | output | 1 | Step input ready, always high |
| ph_valid | output | 1 | Phase output valid |
| ph_data | output | PH_W (16) | Signed phase, 3.13 format |
| ph_last | output | 1 | Stored last flag |
| ph_ready | input | 1 | Downstream accepts the phase |

## Verification
The bench drives sums into the exact boundary values +8191 and -8192, and into sums just past them. A design that compared with the wrong sign or used an off-by-one threshold would wrap a legal value or let an illegal one through. Full-scale steps of ±8192 are also applied. A design that relied on natural overflow, or widened the sum too little, would produce a value outside the range or a wrong value.

The bench loads a step in the same cycle that a beat is accepted. A design with a bypass from the input to the adder would apply the new step one beat early. Clear is applied together with ready and together with a new step, to confirm that clear wins and that the stored step survives.

A reset partway through the run checks that the step itself is cleared, and not only the phase. Holding the phase while ready is low catches a design that advances on valid alone.

// File: rtl/phase_stepper_pkg.sv
package phase_stepper_pkg;

  typedef enum logic [1:0] {
    WRAP_NONE = 2'd0,
    WRAP_DOWN = 2'd1,
    WRAP_UP   = 2'd2
  } wrap_kind_e;

  // Classify an unwrapped sum against the +/-1.0 limits of a format
  // with frac_w fractional bits.
  function automatic wrap_kind_e ps_wrap_kind(input int sum, input int frac_w);
    int unit;
    unit = 1 << frac_w;
    if (sum >= unit)       return WRAP_DOWN;
    else if (sum < -unit)  return WRAP_UP;
    else                   return WRAP_NONE;
  endfunction

  // Apply one full-turn correction (2.0) in the chosen direction.
  function automatic int ps_wrap_apply(input int sum, input wrap_kind_e kind,
                                       input int frac_w);
    int turn;
    turn = 2 << frac_w;
    case (kind)
      WRAP_DOWN: return sum - turn;
      WRAP_UP:   return sum + turn;
      default:   return sum;
    endcase
  endfunction

endpackage

// File: rtl/ps_inc_hold.sv
module ps_inc_hold #(
  parameter int PH_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic signed [PH_W-1:0] step_i,
  input  logic                   last_i,
  output logic signed [PH_W-1:0] step_q,
  output logic                   last_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      step_q <= step_i;
      last_q <= last_i;
    end
  end

endmodule

// File: rtl/ps_wrap_add.sv
module ps_wrap_add
  import phase_stepper_pkg::*;
#(
  parameter int PH_W   = 16,
  parameter int FRAC_W = 13
) (
  input  logic signed [PH_W-1:0] phase_i,
  input  logic signed [PH_W-1:0] step_i,
  output logic signed [PH_W-1:0] next_o,
  output logic                   wrap_hi_o,
  output logic                   wrap_lo_o
);

  int         sum_i;
  int         fixed_i;
  wrap_kind_e kind;

  always_comb begin
    sum_i     = int'(phase_i) + int'(step_i);
    kind      = ps_wrap_kind(sum_i, FRAC_W);
    fixed_i   = ps_wrap_apply(sum_i, kind, FRAC_W);
    next_o    = PH_W'(fixed_i);
    wrap_hi_o = (kind == WRAP_DOWN);
    wrap_lo_o = (kind == WRAP_UP);
  end

endmodule

// File: rtl/ps_phase_reg.sv
module ps_phase_reg #(
  parameter int PH_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_i,
  input  logic                   advance_i,
  input  logic signed [PH_W-1:0] next_i,
  output logic signed [PH_W-1:0] phase_q,
  output logic                   valid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      if (clr_i)          phase_q <= '0;
      else if (advance_i) phase_q <= next_i;
    end
  end

endmodule

// File: rtl/phase_stepper.sv
module phase_stepper #(
  parameter int PH_W   = 16,
  parameter int FRAC_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            inc_valid,
  input  logic [PH_W-1:0] inc_data,
  input  logic            inc_last,
  output logic            inc_ready,
  output logic            ph_valid,
  output logic [PH_W-1:0] ph_data,
  output logic            ph_last,
  input  logic            ph_ready
);

  logic signed [PH_W-1:0] inc_q;
  logic signed [PH_W-1:0] phase_q;
  logic signed [PH_W-1:0] phase_next;
  logic                   last_q;
  logic                   valid_q;
  logic                   step_fire;
  logic                   wrap_hi;
  logic                   wrap_lo;

  assign inc_ready = 1'b1;
  assign step_fire = valid_q & ph_ready;

  ps_inc_hold #(.PH_W(PH_W)) u_inc (
    .clk    (clk),
    .rst    (rst),
    .load_i (inc_valid),
    .step_i ($signed(inc_data)),
    .last_i (inc_last),
    .step_q (inc_q),
    .last_q (last_q)
  );

  ps_wrap_add #(.PH_W(PH_W), .FRAC_W(FRAC_W)) u_add (
    .phase_i   (phase_q),
    .step_i    (inc_q),
    .next_o    (phase_next),
    .wrap_hi_o (wrap_hi),
    .wrap_lo_o (wrap_lo)
  );

  ps_phase_reg #(.PH_W(PH_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr),
    .advance_i (step_fire),
    .next_i    (phase_next),
    .phase_q   (phase_q),
    .valid_q   (valid_q)
  );

  assign ph_valid = valid_q;
  assign ph_data  = phase_q;
  assign ph_last  = last_q;

endmodule

// File: rtl/phase_stepper_chk.sv
module phase_stepper_chk #(
  parameter int PH_W   = 16,
  parameter int FRAC_W = 13
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr,
  input logic                   inc_valid,
  input logic                   inc_last,
  input logic                   ph_valid,
  input logic [PH_W-1:0]        ph_data,
  input logic                   ph_last,
  input logic                   step_fire,
  input logic                   wrap_hi,
  input logic                   wrap_lo,
  input logic signed [PH_W-1:0] inc_q
);

  localparam int              UNIT     = 1 << FRAC_W;
  localparam logic [PH_W-1:0] TURN_MSK = PH_W'((2 << FRAC_W) - 1);

  logic signed [PH_W-1:0] ph_s;
  assign ph_s = $signed(ph_data);

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (rst)
    ph_valid |=> ph_valid); // R1

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inc_valid |=> $stable(inc_q)); // R3

  AST_STEP_MOD: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !clr) |=>
      (((ph_data - $past(ph_data) - $past(inc_q)) & TURN_MSK) == '0)); // R4

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step_fire && !clr) |=> $stable(ph_data)); // R5

  AST_WRAP_DOWN_NEG: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !clr && wrap_hi) |=> (ph_s < 0)); // R6

  AST_WRAP_UP_POS: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !clr && wrap_lo) |=> (ph_s >= 0)); // R7

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(ph_s) >= -UNIT) && (int'(ph_s) < UNIT)); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ph_data == '0)); // R9

  AST_LAST_TRACK: assert property (@(posedge clk) disable iff (rst)
    inc_valid |=> (ph_last == $past(inc_last))); // R10

endmodule

bind phase_stepper phase_stepper_chk #(.PH_W(PH_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .inc_valid (inc_valid),
  .inc_last  (inc_last),
  .ph_valid  (ph_valid),
  .ph_data   (ph_data),
  .ph_last   (ph_last),
  .step_fire (step_fire),
  .wrap_hi   (wrap_hi),
  .wrap_lo   (wrap_lo),
  .inc_q     (inc_q)
);

// File: tb/test_phase_stepper.sv
`timescale 1ns/1ps
module test_phase_stepper;

  localparam int PH_W = 16;
  localparam int NV   = 26;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            clr = 1'b0;
  logic            inc_valid = 1'b0;
  logic [PH_W-1:0] inc_data = '0;
  logic            inc_last = 1'b0;
  logic            inc_ready;
  logic            ph_valid;
  logic [PH_W-1:0] ph_data;
  logic            ph_last;
  logic            ph_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  phase_stepper i_phase_stepper (
    .clk(clk), .rst(rst), .clr(clr),
    .inc_valid(inc_valid), .inc_data(inc_data), .inc_last(inc_last),
    .inc_ready(inc_ready), .ph_valid(ph_valid), .ph_data(ph_data),
    .ph_last(ph_last), .ph_ready(ph_ready)
  );

  // Row layout: {load, last, ready, clr, step[15:0], exp_phase[15:0], exp_last}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b0,  16'sd1000,   16'sd0,    1'b0}, // R3 new step not used yet
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd1000, 1'b0}, // R4
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd2000, 1'b0}, // R4
    {1'b0,1'b0,1'b0,1'b0,  16'sd0,      16'sd2000, 1'b0}, // R5 ready low
    {1'b1,1'b1,1'b0,1'b0,  16'sd3000,   16'sd2000, 1'b1}, // R10
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd5000, 1'b1},
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd8000, 1'b1},
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,     -16'sd5384, 1'b1}, // R6 11000
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,     -16'sd2384, 1'b1},
    {1'b1,1'b0,1'b1,1'b0, -16'sd4000,   16'sd616,  1'b0}, // R3
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,     -16'sd3384, 1'b0},
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,     -16'sd7384, 1'b0},
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd5000, 1'b0}, // R7 -11384
    {1'b0,1'b0,1'b1,1'b1,  16'sd0,      16'sd0,    1'b0}, // R9 clear beats ready
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,     -16'sd4000, 1'b0}, // R9 step kept
    {1'b1,1'b1,1'b0,1'b0,  16'sd8192,  -16'sd4000, 1'b1}, // R11
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd4192, 1'b1},
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,     -16'sd4000, 1'b1}, // R11 12384
    {1'b1,1'b0,1'b1,1'b0, -16'sd8192,   16'sd4192, 1'b0},
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,     -16'sd4000, 1'b0},
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd4192, 1'b0}, // R11 -12192
    {1'b1,1'b0,1'b1,1'b1,  16'sd8191,   16'sd0,    1'b0}, // R9
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd8191, 1'b0}, // R8 top edge kept
    {1'b1,1'b0,1'b1,1'b1, -16'sd8192,   16'sd0,    1'b0}, // R9
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,     -16'sd8192, 1'b0}, // R8 bottom edge kept
    {1'b0,1'b0,1'b1,1'b0,  16'sd0,      16'sd0,    1'b0}  // R11 -16384
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step_clk();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", int'(ph_valid), 0);
    check("R1 phase in reset", int'($signed(ph_data)), 0);
    check("R1 last in reset", int'(ph_last), 0);
    check("R2 ready in reset", int'(inc_ready), 1);
    rst = 1'b0;
    step_clk();
    check("R1 valid after reset", int'(ph_valid), 1);
    check("R1 phase after reset", int'($signed(ph_data)), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      inc_valid = VEC[i][36];
      inc_last  = VEC[i][35];
      ph_ready  = VEC[i][34];
      clr       = VEC[i][33];
      inc_data  = VEC[i][32:17];
      step_clk();
      check($sformatf("R4 phase row %0d", i), int'($signed(ph_data)),
            int'($signed(VEC[i][16:1])));
      check($sformatf("R10 last row %0d", i), int'(ph_last), int'(VEC[i][0]));
      check($sformatf("R2 ready row %0d", i), int'(inc_ready), 1);
      check($sformatf("R1 valid row %0d", i), int'(ph_valid), 1);
    end

    // R3: step loaded in firing cycle applies from the following beat
    inc_valid = 1'b1; inc_data = 16'd500; inc_last = 1'b1;
    clr = 1'b0; ph_ready = 1'b1;
    step_clk();
    check("R3 old step used", int'($signed(ph_data)), -8192);
    inc_valid = 1'b0;
    step_clk();
    check("R3 new step used", int'($signed(ph_data)), -7692);

    // R1: reset mid-run clears the step too
    rst = 1'b1;
    step_clk();
    check("R1 valid mid reset", int'(ph_valid), 0);
    check("R1 phase mid reset", int'($signed(ph_data)), 0);
    check("R1 last mid reset", int'(ph_last), 0);
    rst = 1'b0;
    step_clk();
    check("R1 valid rerelease", int'(ph_valid), 1);
    step_clk();
    step_clk();
    check("R1 step cleared", int'($signed(ph_data)), 0);

    // R9: clear with ready low still zeroes, last kept
    inc_valid = 1'b1; inc_data = 16'd700; inc_last = 1'b1;
    step_clk();
    inc_valid = 1'b0;
    step_clk();
    check("R4 after reload", int'($signed(ph_data)), 700);
    ph_ready = 1'b0; clr = 1'b1;
    step_clk();
    check("R9 clear ready low", int'($signed(ph_data)), 0);
    check("R9 last kept", int'(ph_last), 1);
    clr = 1'b0; ph_ready = 1'b1;
    step_clk();
    check("R9 step kept", int'($signed(ph_data)), 700);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule